// File: doc/BRIEF.md
# Posted-Write SRAM Front End with Read Bypass

This block sits between a command source and a synchronous single-port SRAM that runs with late (posted) writes. An accepted write is not sent to the array in its own cycle. Its address and data go into a one-entry holding register. That held write reaches the array only when the next accepted write arrives. In that same cycle the new write takes its place in the holding register. A read always starts an array access. If a write is pending and its address equals the read address, the held data is returned instead of the array word. The result comes out exactly one cycle after the read command in both cases.

The block also enforces the read-to-write bus turnaround. A write needs at least one idle cycle after the most recent read. When the `extraIdle` input is high, it needs two. A write that comes too early is refused and reported. A read may follow a write directly.

Top module: `posted_write_front`

## Requirements
- R1: During and after reset, `rdValid` and `protoErr` are low, no write is pending, and idle commands cause no array access (`memEn` low).
- R2: A write accepted while nothing is pending produces no array write, and the array keeps its old contents at that address.
- R3: An accepted write while a write is pending writes the pending address and data to the array in that same cycle (`memEn` and `memWe` high), and the new write becomes the pending one.
- R4: A read command (`cmdOp` = 2'b01) issued in cycle t gives `rdValid` high for exactly cycle t+1, with the result on `rdData`.
- R5: A read whose full address equals the pending write address returns the pending write data.
- R6: A read that does not match the pending address returns the array word at that address. An address that differs in any single bit, the top bit included, does not match.
- R7: Before the first accepted write after reset, every read returns array contents, even at address 0.
- R8: A write (`cmdOp` = 2'b10) issued with too few non-read cycles since the last read is refused. The array is not written, the pending entry is unchanged, and `protoErr` is high in the next cycle. A refused write still counts as a non-read cycle.
- R9: With `extraIdle` low, one non-read cycle between a read and a write is enough. With `extraIdle` high, two are needed.
- R10: A read may directly follow a write with no idle cycle. A read of the address just written returns the newly written data.
- R11: Command code 2'b11 behaves exactly like idle (2'b00). It makes no array access and counts as a non-read cycle for the turnaround rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| extraIdle | input | 1 | High: two turnaround cycles required from read to write |
| cmdOp | input | 2 | 00 idle, 01 read, 10 write, 11 treated as idle |
| cmdAddr | input | ADDR_W (16) | Word address of the command |
| cmdData | input | DATA_W (32) | Write data |
| memEn | output | 1 | Array access enable |
| memWe | output | 1 | Array write enable (valid with memEn) |
| memAddr | output | ADDR_W | Array address |
| memWdata | output | DATA_W | Array write data |
| memRdata | input | DATA_W | Array read data, one cycle after a read access |
| rdValid | output | 1 | Read result valid |
| rdData | output | DATA_W | Read result |
| protoErr | output | 1 | Pulse: the previous write was refused |

## Verification
Two functions fall into one cycle on every accepted write: the pending write is committed to the array and the incoming write is captured into the holding register. The bench provokes this with write, idle and write sequences. It then reads back both the committed address and the new address. The committed address must come from the array and the new one from the bypass. The bench also inspects its own array model right after each write. Turnaround violations are placed around these pairs, so that refused writes must leave both the array and the pending entry unchanged.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  // Strobes from control to datapath, valid in the command cycle
  typedef struct packed {
    logic rdIssue;   // start an array read and sample the bypass compare
    logic wrAccept;  // load the holding register with the command
    logic commit;    // push the held write into the array
    logic wrReject;  // write refused by the turnaround rule
  } strobe_t;

endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int GAP_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       extraIdle,
  input  logic [1:0] cmdOp,
  input  logic       pending,
  output strobe_t    strb
);

  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};
  localparam logic [GAP_W-1:0] NEED_LO = GAP_W'(1);
  localparam logic [GAP_W-1:0] NEED_HI = GAP_W'(2);

  // Non-read cycles seen since the last read, saturating
  logic [GAP_W-1:0] gapCnt;
  logic             isRead;
  logic             isWrite;
  logic             gapOk;

  assign isRead  = (cmdOp == OP_READ);
  assign isWrite = (cmdOp == OP_WRITE);
  assign gapOk   = (gapCnt >= (extraIdle ? NEED_HI : NEED_LO));

  always_comb begin
    strb          = '0;
    strb.rdIssue  = isRead;
    strb.wrAccept = isWrite && gapOk;
    strb.wrReject = isWrite && !gapOk;
    strb.commit   = isWrite && gapOk && pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt <= GAP_MAX;
    end else if (isRead) begin
      gapCnt <= '0;
    end else if (gapCnt != GAP_MAX) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              protoErr,
  output logic              pending
);

  // Holding register for the posted write
  logic              bufValid;
  logic [ADDR_W-1:0] bufAddr;
  logic [DATA_W-1:0] bufData;

  // Read result pipeline
  logic              rdValidQ;
  logic              hitQ;
  logic [DATA_W-1:0] hitDataQ;
  logic              errQ;

  logic              addrHit;

  // Compare enabled only while a write is held
  assign addrHit = bufValid && (bufAddr == cmdAddr);

  assign memEn    = strb.rdIssue || strb.commit;
  assign memWe    = strb.commit;
  assign memAddr  = strb.commit ? bufAddr : cmdAddr;
  assign memWdata = bufData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufValid <= 1'b0;
      bufAddr  <= '0;
      bufData  <= '0;
    end else if (strb.wrAccept) begin
      bufValid <= 1'b1;
      bufAddr  <= cmdAddr;
      bufData  <= cmdData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdValidQ <= 1'b0;
      hitQ     <= 1'b0;
      hitDataQ <= '0;
      errQ     <= 1'b0;
    end else begin
      rdValidQ <= strb.rdIssue;
      hitQ     <= strb.rdIssue && addrHit;
      errQ     <= strb.wrReject;
      if (strb.rdIssue) begin
        hitDataQ <= bufData;
      end
    end
  end

  assign rdValid  = rdValidQ;
  assign rdData   = hitQ ? hitDataQ : memRdata;
  assign protoErr = errQ;
  assign pending  = bufValid;

endmodule

// File: rtl/posted_write_front.sv
module posted_write_front
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              extraIdle,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              protoErr
);

  strobe_t strb;
  logic    pending;

  pwb_ctrl #(.GAP_W(2)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .extraIdle(extraIdle),
    .cmdOp    (cmdOp),
    .pending  (pending),
    .strb     (strb)
  );

  pwb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .cmdAddr (cmdAddr),
    .cmdData (cmdData),
    .memRdata(memRdata),
    .memEn   (memEn),
    .memWe   (memWe),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .rdValid (rdValid),
    .rdData  (rdData),
    .protoErr(protoErr),
    .pending (pending)
  );

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker
  import pwb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmdOp,
  input logic       memEn,
  input logic       memWe,
  input logic       rdValid,
  input logic       protoErr,
  input logic       pending
);

  a_r4_read_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdOp == OP_READ) |=> rdValid);

  a_r4_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> ($past(cmdOp) == OP_READ));

  a_r8_b2b_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmdOp == OP_WRITE) && ($past(cmdOp) == OP_READ)) |-> !memWe);

  a_r8_b2b_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmdOp == OP_WRITE) && ($past(cmdOp) == OP_READ)) |=> protoErr);

  a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    protoErr |-> (($past(cmdOp) == OP_WRITE) && !$past(memWe)));

  a_r3_commit_needs_pending_write: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> ((cmdOp == OP_WRITE) && pending && memEn));

  a_r2_first_write_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmdOp == OP_WRITE) && !pending) |-> !memWe);

  a_r11_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmdOp == OP_IDLE) || (cmdOp == OP_RSVD)) |-> !memEn);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending) |-> !memWe);

endmodule

bind posted_write_front pwb_checker i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmdOp   (cmdOp),
  .memEn   (memEn),
  .memWe   (memWe),
  .rdValid (rdValid),
  .protoErr(protoErr),
  .pending (pending)
);

// File: tb/test_posted_write_front.sv
`timescale 1ns/1ps
module test_posted_write_front;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10, RSV = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          extraIdle = 1'b0;
  logic [1:0]    cmdOp = NOP;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdData = '0;
  logic          memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata = '0;
  logic          rdValid;
  logic [DW-1:0] rdData;
  logic          protoErr;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  posted_write_front #(.ADDR_W(AW), .DATA_W(DW)) i_posted_write_front (
    .clk(clk), .rst_n(rst_n), .extraIdle(extraIdle),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .rdValid(rdValid), .rdData(rdData), .protoErr(protoErr)
  );

  // Behavioural array: sparse, with computed initial contents
  logic [DW-1:0] ram [logic [AW-1:0]];

  function automatic logic [DW-1:0] initVal(logic [AW-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  function automatic logic [DW-1:0] ramPeek(logic [AW-1:0] a);
    if (ram.exists(a)) return ram[a];
    return initVal(a);
  endfunction

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) ram[memAddr] = memWdata;
      else memRdata <= ramPeek(memAddr);
    end
  end

  task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model built from the requirements
  typedef struct {
    bit            isRead;
    bit            err;
    logic [DW-1:0] data;
    string         req;
  } exp_t;

  exp_t          expQ[$];
  bit            refValid = 0;
  logic [AW-1:0] refAddr = '0;
  logic [DW-1:0] refData = '0;
  logic [DW-1:0] refMem [logic [AW-1:0]];
  int            refGap = 100;

  function automatic logic [DW-1:0] refRead(logic [AW-1:0] a);
    if (refValid && refAddr == a) return refData;
    if (refMem.exists(a)) return refMem[a];
    return initVal(a);
  endfunction

  task automatic issue(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d, string req);
    exp_t e;
    int need;
    @(negedge clk);
    cmdOp = op; cmdAddr = a; cmdData = d;
    e.isRead = (op == RD); e.err = 0; e.data = '0; e.req = req;
    need = extraIdle ? 2 : 1;
    if (op == RD) begin
      e.data = refRead(a);
      refGap = 0;
    end else begin
      if (op == WR) begin
        if (refGap >= need) begin
          if (refValid) refMem[refAddr] = refData;
          refValid = 1; refAddr = a; refData = d;
        end else begin
          e.err = 1;
        end
      end
      refGap++;
    end
    expQ.push_back(e);
    if (op == NOP || op == RSV) begin
      #1;
      check(memEn == 1'b0, (op == RSV) ? "R11" : req, "memEn on idle", {31'b0, memEn}, '0);
    end
  endtask

  // Monitor: one expected record per command cycle
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(rdValid == e.isRead, e.isRead ? "R4" : e.req, "rdValid", {31'b0, rdValid}, {31'b0, e.isRead});
      if (e.isRead && rdValid)
        check(rdData == e.data, e.req, "rdData", rdData, e.data);
      check(protoErr == e.err, e.err ? "R8" : e.req, "protoErr", {31'b0, protoErr}, {31'b0, e.err});
    end
  end

  task automatic peekRam(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
    @(posedge clk); #1;
    check(ramPeek(a) == exp, req, "array word", ramPeek(a), exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  localparam logic [AW-1:0] A = 16'h0100, B = 16'h0200, C = 16'h0300;
  localparam logic [DW-1:0] D1 = 32'hCAFE_0001, D2 = 32'hBEEF_0002, D3 = 32'h1234_5678;

  initial begin
    repeat (3) @(negedge clk);
    check(rdValid == 0 && protoErr == 0 && memEn == 0, "R1", "outputs in reset",
          {29'b0, rdValid, protoErr, memEn}, '0);
    @(negedge clk); rst_n = 1'b1;
    issue(NOP, '0, '0, "R1");
    issue(RD, 16'h0000, '0, "R7");            // no pending write yet
    issue(NOP, '0, '0, "R1");
    issue(WR, A, D1, "R2");
    peekRam(A, initVal(A), "R2");             // held, not in the array
    issue(RD, A, '0, "R10");                  // back to back read, bypass
    issue(RD, B, '0, "R6");                   // miss
    issue(RD, A ^ 16'h8000, '0, "R6");        // top bit differs
    issue(RD, A, '0, "R5");
    issue(NOP, '0, '0, "R9");
    issue(WR, C, D2, "R3");                   // commits A, captures C
    peekRam(A, D1, "R3");
    check(ramPeek(C) == initVal(C), "R3", "new write held", ramPeek(C), initVal(C));
    issue(RD, A, '0, "R6");                   // now from array
    issue(RD, C, '0, "R5");
    issue(WR, B, D3, "R8");                   // no idle: refused
    issue(RD, C, '0, "R8");                   // pending still C
    issue(RD, B, '0, "R8");
    issue(NOP, '0, '0, "R9");
    peekRam(B, initVal(B), "R8");
    extraIdle = 1'b1;
    issue(RD, A, '0, "R9");
    issue(NOP, '0, '0, "R9");
    issue(WR, B, D3, "R9");                   // one idle only: refused
    issue(WR, B, D3, "R9");                   // refused write counted: accepted
    issue(RD, B, '0, "R9");
    issue(RD, C, '0, "R9");                   // C was committed
    issue(RSV, B, 32'hFFFF_FFFF, "R11");
    issue(RSV, B, 32'hFFFF_FFFF, "R11");
    issue(WR, A, D2, "R11");                  // two reserved ops count as idle
    issue(RD, A, '0, "R11");
    extraIdle = 1'b0;
    issue(RSV, '0, '0, "R11");
    for (int i = 0; i < 600; i++) begin
      if (i == 300) extraIdle = 1'b1;
      issue(2'($urandom_range(0, 3)), 16'h0040 + 16'($urandom_range(0, 3)), $urandom, "R3");
    end
    issue(NOP, '0, '0, "R1");
    repeat (4) @(posedge clk);
    #1;
    check(expQ.size() == 0, "R4", "results drained", 32'(expQ.size()), '0);
    summary();
  end

endmodule